// File: doc/BRIEF.md
# SPI Serial EEPROM Target Controller

This block is the target-side logic of a small serial EEPROM reached over SPI. The 512-byte array sits in on-chip registers and starts out erased (every byte 0xFF). The block runs on a fast system clock. It samples chip select, the serial clock and serial data in on that clock, and it finds the edges of the serial clock itself. Data comes out on a serial output with a separate output enable, so the pad can be tri-stated whenever the block is not driving data.

A host issues 8-bit instructions, MSB first:
- set and clear a write-enable latch;
- read and write a status byte;
- read the array sequentially;
- write up to one 16-byte page.

The ninth address bit travels inside the read and write opcode bytes. Two block-protect bits guard the upper quarter, the upper half or the whole array against writes. An active-low write-protect pin holds the write-enable latch cleared. A committed write or status write starts an internal write cycle that lasts a fixed number of clocks. While that cycle runs, only the status read is obeyed.

Top module: `spi_eeprom`

## Requirements
- R1: After reset the status byte reads 0x00 and the output enable is low. Status layout: bit0 busy, bit1 write-enable latch, bit2/bit3 protect level low/high bit, bits 7:4 zero.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each acts once its eighth bit is received.
- R3: While wp_n_i is low the write-enable latch reads 0, including after a 0x06 instruction.
- R4: Opcode {4'b0000, A8, 3'b011} followed by an address byte A7..A0 returns array bytes MSB first. The address increments after each byte and wraps from 0x1FF to 0x000.
- R5: Opcode {4'b0000, A8, 3'b010}, an address byte and data bytes load a page buffer; addresses wrap inside the 16-byte page. The page is written at chip-select rise only if the latch was set and at least one full data byte arrived. With the latch clear the frame has no effect.
- R6: A committed write holds the busy bit at 1 for WR_CYCLES clocks after chip-select rise. It then returns to 0 and clears the write-enable latch.
- R7: Opcode 0x05 returns the current status byte, repeated for as long as chip select stays low. It is honoured during a write cycle.
- R8: Opcode 0x01 followed by a data byte loads the protect level from data bits 3:2 through a write cycle, and only when the latch is set.
- R9: Protect level 1 guards 0x180-0x1FF, level 2 guards 0x100-0x1FF and level 3 guards everything. A write to a guarded page changes nothing, starts no cycle and leaves the latch set. Guarded bytes remain readable.
- R10: so_oe_o is high only while data or status bytes are being shifted out. It is low during the opcode and address phases and while chip select is high.
- R11: During a write cycle every instruction other than 0x05 is ignored, including 0x06 and reads.
- R12: If chip select rises before the opcode (and, for reads and writes, the address) is complete, the frame has no effect.
- R13: SPI mode 0 (clock idles low) and mode 3 (clock idles high) both work. Input is sampled on the rising serial-clock edge and output changes on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data from the host |
| wp_n_i | input | 1 | Write protect, active low |
| so_o | output | 1 | Serial data to the host |
| so_oe_o | output | 1 | Output enable for so_o (low means high impedance) |

## Verification
The bench targets several corner cases, and each one exposes a specific design fault:
- Sequential reads across the 0x1FF to 0x000 boundary and page writes that wrap inside their 16-byte page. A design that carries into the next page or stops at the array end returns wrong bytes.
- Instructions sent during a write cycle. A controller that lets 0x06 through leaves the latch set afterwards, and one that serves reads while busy drives the output.
- Frames cut short inside the opcode or address, and writes to each guarded region. Any side effect shows up in the status byte or in read-back data.
- The write-protect pin asserted after the latch has been set, and every operation repeated in mode 3. In mode 3 the extra idle-high clock edge must not shift the output by one bit.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_SRIN,
        PH_RDOUT,
        PH_SROUT,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OPC_SET_WEL = 8'h06;
    localparam logic [7:0] OPC_CLR_WEL = 8'h04;
    localparam logic [7:0] OPC_GET_SR  = 8'h05;
    localparam logic [7:0] OPC_PUT_SR  = 8'h01;
    localparam logic [2:0] OPC_RD_TAIL = 3'b011;
    localparam logic [2:0] OPC_WR_TAIL = 3'b010;

    function automatic logic [7:0] mk_status(input logic [1:0] lvl,
                                             input logic       wel,
                                             input logic       busy);
        return {4'b0000, lvl, wel, busy};
    endfunction

endpackage

// File: rtl/spi_eeprom_guard.sv
module spi_eeprom_guard (
    input  logic [1:0] lvl_i,
    input  logic [1:0] top_bits_i,
    output logic       guarded_o
);
    always_comb begin
        unique case (lvl_i)
            2'd0:    guarded_o = 1'b0;
            2'd1:    guarded_o = top_bits_i[1] & top_bits_i[0];
            2'd2:    guarded_o = top_bits_i[1];
            default: guarded_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_eeprom_store.sv
module spi_eeprom_store #(
    parameter int AW = 9,
    parameter int PW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [PW-1:0]    idx_i,
    input  logic [7:0]       byte_i,
    input  logic             commit_i,
    input  logic [AW-PW-1:0] page_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [7:0]       rd_data_o
);
    localparam int DEPTH = 1 << AW;
    localparam int PBYTES = 1 << PW;

    logic [7:0]        mem_q  [DEPTH];
    logic [7:0]        pbuf_q [PBYTES];
    logic [PBYTES-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            for (int k = 0; k < PBYTES; k++) pbuf_q[k] <= 8'h00;
            mask_q <= '0;
        end else begin
            if (clr_i) mask_q <= '0;
            if (we_i) begin
                pbuf_q[idx_i] <= byte_i;
                mask_q[idx_i] <= 1'b1;
            end
            if (commit_i) begin
                for (int k = 0; k < PBYTES; k++) begin
                    if (mask_q[k]) mem_q[{page_i, PW'(k)}] <= pbuf_q[k];
                end
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (mask_q != '0)); // R5

endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom #(
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic wp_n_i,
    output logic so_o,
    output logic so_oe_o
);
    import spi_eeprom_pkg::*;

    localparam int AW    = 9;
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic             sck;
        logic             csn;
        phase_e           ph;
        logic [2:0]       bits;
        logic [7:0]       sh;
        logic             is_rd;
        logic [AW-1:0]    addr;
        logic [7:0]       osh;
        logic             oen;
        logic             load;
        logic             wel;
        logic [1:0]       lvl;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             wr_pend;
        logic             sr_pend;
        logic [1:0]       sr_val;
    } st_t;

    st_t st_d, st_q;

    logic          commit, buf_clr, buf_we;
    logic [7:0]    buf_byte, rd_data, byte_in;
    logic          guarded, rise, fall;

    spi_eeprom_guard i_guard (
        .lvl_i      (st_q.lvl),
        .top_bits_i (st_q.addr[AW-1:AW-2]),
        .guarded_o  (guarded)
    );

    spi_eeprom_store #(.AW(AW), .PW(PW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .we_i      (buf_we),
        .idx_i     (st_q.addr[PW-1:0]),
        .byte_i    (buf_byte),
        .commit_i  (commit),
        .page_i    (st_q.addr[AW-1:PW]),
        .rd_addr_i (st_q.addr),
        .rd_data_o (rd_data)
    );

    always_comb begin
        st_d     = st_q;
        commit   = 1'b0;
        buf_clr  = 1'b0;
        buf_we   = 1'b0;
        buf_byte = 8'h00;
        rise     = sck_i & ~st_q.sck;
        fall     = ~sck_i & st_q.sck;
        byte_in  = {st_q.sh[6:0], mosi_i};
        st_d.sck = sck_i;
        st_d.csn = cs_n_i;

        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (cs_n_i) begin
            st_d.ph   = PH_IDLE;
            st_d.oen  = 1'b0;
            st_d.load = 1'b0;
            st_d.bits = '0;
            if (!st_q.csn && !st_q.busy && st_q.wel) begin
                if (st_q.ph == PH_WDATA && st_q.wr_pend && !guarded) begin
                    commit    = 1'b1;
                    st_d.busy = 1'b1;
                    st_d.cnt  = CNT_W'(WR_CYCLES - 1);
                end else if (st_q.sr_pend) begin
                    st_d.lvl  = st_q.sr_val;
                    st_d.busy = 1'b1;
                    st_d.cnt  = CNT_W'(WR_CYCLES - 1);
                end
            end
            st_d.wr_pend = 1'b0;
            st_d.sr_pend = 1'b0;
        end else if (st_q.csn) begin
            st_d.ph   = PH_CMD;
            st_d.bits = '0;
        end else if (rise) begin
            st_d.sh   = byte_in;
            st_d.bits = st_q.bits + 3'd1;
            if (st_q.bits == 3'd7) begin
                unique case (st_q.ph)
                    PH_CMD: begin
                        st_d.ph = PH_SKIP;
                        if (byte_in == OPC_GET_SR) begin
                            st_d.ph   = PH_SROUT;
                            st_d.load = 1'b1;
                        end else if (!st_q.busy) begin
                            if (byte_in == OPC_SET_WEL) begin
                                st_d.wel = 1'b1;
                            end else if (byte_in == OPC_CLR_WEL) begin
                                st_d.wel = 1'b0;
                            end else if (byte_in == OPC_PUT_SR) begin
                                if (st_q.wel) st_d.ph = PH_SRIN;
                            end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == OPC_RD_TAIL) begin
                                st_d.is_rd      = 1'b1;
                                st_d.addr[AW-1] = byte_in[3];
                                st_d.ph         = PH_ADDR;
                            end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == OPC_WR_TAIL
                                         && st_q.wel) begin
                                st_d.is_rd      = 1'b0;
                                st_d.addr[AW-1] = byte_in[3];
                                st_d.ph         = PH_ADDR;
                            end
                        end
                    end
                    PH_ADDR: begin
                        st_d.addr[7:0] = byte_in;
                        if (st_q.is_rd) begin
                            st_d.ph   = PH_RDOUT;
                            st_d.load = 1'b1;
                        end else begin
                            st_d.ph = PH_WDATA;
                            buf_clr = 1'b1;
                        end
                    end
                    PH_WDATA: begin
                        buf_we            = 1'b1;
                        buf_byte          = byte_in;
                        st_d.wr_pend      = 1'b1;
                        st_d.addr[PW-1:0] = st_q.addr[PW-1:0] + 1'b1;
                    end
                    PH_SRIN: begin
                        st_d.sr_val  = byte_in[3:2];
                        st_d.sr_pend = 1'b1;
                        st_d.ph      = PH_SKIP;
                    end
                    PH_RDOUT: begin
                        st_d.addr = st_q.addr + 1'b1;
                        st_d.load = 1'b1;
                    end
                    PH_SROUT: st_d.load = 1'b1;
                    default: ;
                endcase
            end
        end else if (fall && (st_q.ph == PH_RDOUT || st_q.ph == PH_SROUT)) begin
            if (st_q.load) begin
                st_d.osh  = (st_q.ph == PH_RDOUT) ? rd_data
                                                  : mk_status(st_q.lvl, st_q.wel, st_q.busy);
                st_d.oen  = 1'b1;
                st_d.load = 1'b0;
            end else begin
                st_d.osh = {st_q.osh[6:0], 1'b0};
            end
        end

        if (!wp_n_i) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.csn <= 1'b1;
            st_q.ph  <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign so_o    = st_q.oen & st_q.osh[7];
    assign so_oe_o = st_q.oen;

    AST_WP_FORCES_WEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i |=> !st_q.wel); // R3

    AST_SO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !so_oe_o); // R10

    AST_CYCLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> st_q.busy); // R6

    AST_CYCLE_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> !st_q.wel); // R6

    AST_NO_COMMIT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !st_q.busy); // R11

    AST_LEVEL_ONLY_WITH_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> st_q.busy); // R8

endmodule

// File: tb/test_spi_eeprom.sv
module test_spi_eeprom;

    localparam int WRC = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic so, so_oe;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit mode3 = 0;

    logic [7:0] m_mem [512];
    logic       m_wel = 1'b0;
    logic [1:0] m_lvl = 2'd0;

    always #4 clk = ~clk;

    spi_eeprom #(.PAGE_BYTES(16), .WR_CYCLES(WRC)) i_spi_eeprom (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
        .wp_n_i(wp_n), .so_o(so), .so_oe_o(so_oe)
    );

    function automatic bit guarded_of(input logic [1:0] lvl, input logic [8:0] a);
        case (lvl)
            2'd0: return 1'b0;
            2'd1: return a[8] & a[7];
            2'd2: return a[8];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] status_of(input logic busy);
        return {4'b0000, m_lvl, m_wel, busy};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        sck = mode3;
        tick(2);
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic frame_end();
        if (!mode3) sck = 1'b0;
        tick(4);
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                         output bit oe_any, output bit oe_all);
        rx = 8'h00; oe_any = 0; oe_all = 1;
        for (int i = 7; i > 7 - n; i--) begin
            sck = 1'b0;
            mosi = tx[i];
            tick(4);
            rx[i] = so;
            if (so_oe) oe_any = 1; else oe_all = 0;
            sck = 1'b1;
            tick(4);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                         output bit oe_any, output bit oe_all);
        xbits(tx, 8, rx, oe_any, oe_all);
    endtask

    task automatic send_op(input logic [7:0] op);
        logic [7:0] r; bit a, b;
        frame_begin();
        xbyte(op, r, a, b);
        frame_end();
        if (!m_wel_busy_lock) begin
            if (op == 8'h06) m_wel = wp_n;
            if (op == 8'h04) m_wel = 1'b0;
        end
    endtask

    bit m_wel_busy_lock = 0;

    task automatic get_status(output logic [7:0] s);
        logic [7:0] r; bit a, b, a2, b2;
        frame_begin();
        xbyte(8'h05, r, a, b);
        xbyte(8'h00, s, a2, b2);
        frame_end();
        check("R10 status header oe", a, 0);
        check("R10 status data oe", b2, 1);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            get_status(s);
            if (!s[0]) break;
        end
        m_wel = 1'b0;
        check("R6 status after cycle", s, status_of(1'b0));
    endtask

    task automatic read_mem(input logic [8:0] a, input int n);
        logic [7:0] r; bit oa, ol, hdr_oe;
        frame_begin();
        xbyte({4'b0000, a[8], 3'b011}, r, oa, ol);
        hdr_oe = oa;
        xbyte(a[7:0], r, oa, ol);
        hdr_oe |= oa;
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, oa, ol);
            check($sformatf("R4 read @%0h", 9'(a + i)), r, m_mem[9'(a + i)]);
            if (i == 0) check("R10 read data oe", ol, 1);
        end
        frame_end();
        check("R10 read header oe", hdr_oe, 0);
    endtask

    task automatic write_page(input logic [8:0] a, input int n, input bit wait_end);
        logic [7:0] r, d; bit oa, ol;
        bit cyc;
        logic [3:0] lo;
        cyc = m_wel && (n > 0) && !guarded_of(m_lvl, a);
        frame_begin();
        xbyte({4'b0000, a[8], 3'b010}, r, oa, ol);
        xbyte(a[7:0], r, oa, ol);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            xbyte(d, r, oa, ol);
            lo = 4'(a[3:0] + 4'(i));
            if (cyc) m_mem[{a[8:4], lo}] = d;
        end
        frame_end();
        if (cyc) begin
            get_status(r);
            check("R6 busy right after write", r[0], 1);
            if (wait_end) wait_idle();
        end else begin
            get_status(r);
            check("R5/R9 no cycle, status kept", r, status_of(1'b0));
        end
    endtask

    task automatic put_level(input logic [1:0] lvl);
        logic [7:0] r; bit oa, ol;
        bit cyc = m_wel;
        frame_begin();
        xbyte(8'h01, r, oa, ol);
        xbyte({4'b0000, lvl, 2'b11}, r, oa, ol);
        frame_end();
        if (cyc) begin
            m_lvl = lvl;
            wait_idle();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, r;
        bit oa, ol;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) m_mem[i] = 8'hFF;
        tick(5);
        check("R1 oe after reset", so_oe, 0);
        rst_n = 1'b1;
        tick(5);
        check("R1 oe idle", so_oe, 0);
        get_status(s);
        check("R1 reset status", s, 8'h00);

        send_op(8'h06); get_status(s);
        check("R2 set latch", s, 8'h02);
        send_op(8'h04); get_status(s);
        check("R2 clear latch", s, 8'h00);

        write_page(9'h010, 4, 1);
        read_mem(9'h010, 4);                        // R5 no write without latch

        send_op(8'h06);
        write_page(9'h1F8, 12, 1);                  // R5 wraps in page 0x1F0
        read_mem(9'h1F0, 34);                       // R4 crosses 0x1FF->0x000

        // R11: instructions during a write cycle
        send_op(8'h06);
        write_page(9'h020, 3, 0);
        frame_begin(); xbyte(8'h06, r, oa, ol); frame_end();
        frame_begin();
        xbyte(8'h03, r, oa, ol); xbyte(8'h20, r, oa, ol); xbyte(8'h00, r, oa, ol);
        frame_end();
        check("R11 read ignored while busy", oa | ol, 0);
        get_status(s);
        check("R7 status served while busy", s, 8'h03);
        wait_idle();
        get_status(s);
        check("R11 latch set ignored while busy", s, 8'h00);
        read_mem(9'h020, 3);

        // R3 write-protect pin
        wp_n = 1'b0; send_op(8'h06); get_status(s);
        check("R3 latch held low", s[1], 0);
        wp_n = 1'b1; send_op(8'h06); get_status(s);
        check("R3 latch set with pin high", s[1], 1);
        wp_n = 1'b0; tick(3); m_wel = 1'b0; get_status(s);
        check("R3 pin clears latch", s[1], 0);
        wp_n = 1'b1;

        // R8/R9 protect levels
        for (int lv = 1; lv < 4; lv++) begin
            send_op(8'h06);
            put_level(2'(lv));
            get_status(s);
            check("R8 level loaded", s, {4'b0, 2'(lv), 2'b00});
            send_op(8'h06);
            write_page(9'h190, 2, 1);               // R9 guarded at every level
            write_page(9'h170, 2, 1);
            write_page(9'h0A0, 2, 1);
            read_mem(9'h170, 2);
            read_mem(9'h190, 2);
            read_mem(9'h0A0, 2);
        end
        send_op(8'h06); put_level(2'd0);
        check("R9 latch model", m_wel, 0);

        // R12 aborted frames
        send_op(8'h06);
        frame_begin(); xbits(8'h04, 5, r, oa, ol); frame_end();
        get_status(s);
        check("R12 partial opcode no effect", s, 8'h02);
        frame_begin();
        xbyte(8'h02, r, oa, ol); xbits(8'h40, 5, r, oa, ol);
        frame_end();
        get_status(s);
        check("R12 partial address no write", s, 8'h02);
        frame_begin();
        xbyte(8'h03, r, oa, ol); xbits(8'h00, 4, r, oa, ol);
        frame_end();
        check("R12 partial read no output", oa | ol, 0);
        read_mem(9'h040, 2);

        // R13 mode 3 plus random traffic in both modes
        mode3 = 1;
        get_status(s);
        check("R13 mode3 status", s, status_of(1'b0));
        for (int t = 0; t < 28; t++) begin
            int kind = int'($urandom_range(0, 5));
            logic [8:0] a = 9'($urandom);
            mode3 = bit'($urandom_range(0, 1));
            if (kind <= 2) begin
                send_op(8'h06);
                write_page(a, int'($urandom_range(1, 20)), 1);
            end else if (kind <= 4) begin
                read_mem(a, int'($urandom_range(1, 24)));
            end else begin
                send_op(8'h06);
                put_level(2'($urandom));
            end
        end
        mode3 = 1;
        read_mem(9'h1F0, 20);                       // R13 R4 in mode 3

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule